// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block holds the 8-bit modem control setting of a 16C550-style UART and carries out what that setting asks for. The host writes a byte through a single write strobe, and the stored byte can always be read back. The register drives several things: an active-low data-terminal-ready line, the output enable for the interrupt pin, the Xon-Any enable flag passed to the flow-control logic, and the prescaler in front of the baud generator. That prescaler either passes every clock or gives one clock enable in every four.

Setting the loopback bit takes the UART off its serial and modem pins. The transmit pin rests at mark and the transmit bit stream goes straight back to the receiver input. The four modem status bits then follow the control bits rather than the pins: RTS goes to CTS, DTR to DSR, OP1 to RI and OP2 (the interrupt-enable bit) to CD. RTS exists only inside this loop and has no pin.

The status bits, the serial routing and the DTR pin are registered. They follow a change in the register or the pins one clock later. The control byte itself, the interrupt enable and the Xon-Any flag come straight from the register.

Top module: `uart_mdmctl_top`

## Requirements
- R1: Synchronous reset clears the control byte to 0x00, drives `dtr_n` and `tx_pin` to 1, and drives `irq_oe`, `xon_any_en` and `baud_ce` to 0.
- R2: A cycle with `wr_en` high stores `wr_data`, and `rd_data` shows it exactly (bit 6 included) after that clock edge.
- R3: Outside loopback, `dtr_n` is the inverse of control bit 0. With loopback set (bit 4), `dtr_n` is held at 1. It follows one clock after the register.
- R4: `irq_oe` equals control bit 3 (1 = drive the interrupt pin, 0 = high impedance).
- R5: `xon_any_en` equals control bit 5.
- R6: With bit 4 at 0, one clock later the status outputs are the complements of the active-low modem pins (`st_cts` = !`modem_cts_n`, and likewise for the others), `tx_pin` follows `tx_ser` and `rx_rcv` follows `rx_pin`.
- R7: With bit 4 at 1, one clock later `st_cts` = bit 1, `st_dsr` = bit 0, `st_ri` = bit 2 and `st_cd` = bit 3, whatever the modem pins do.
- R8: With bit 4 at 1, one clock later `tx_pin` is 1 and `rx_rcv` follows `tx_ser`, whatever `rx_pin` does.
- R9: While bit 7 is 0, `baud_ce` is high on every clock.
- R10: While bit 7 is 1, `baud_ce` is high for one clock in every four and is never high on two clocks in a row.
- R11: A cycle with `wr_en` low leaves the control byte unchanged, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to store |
| rd_data | output | 8 | Stored control byte |
| modem_cts_n | input | 1 | Clear-to-send pin, active low |
| modem_dsr_n | input | 1 | Data-set-ready pin, active low |
| modem_ri_n | input | 1 | Ring-indicator pin, active low |
| modem_cd_n | input | 1 | Carrier-detect pin, active low |
| rx_pin | input | 1 | External serial receive pin |
| tx_ser | input | 1 | Serial stream from the transmitter |
| tx_pin | output | 1 | External serial transmit pin |
| rx_rcv | output | 1 | Serial stream to the receiver |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| irq_oe | output | 1 | Output enable of the interrupt pin |
| xon_any_en | output | 1 | Any received character resumes the transmitter |
| baud_ce | output | 1 | Clock enable for the baud divisor |
| st_cts | output | 1 | CTS modem status bit |
| st_dsr | output | 1 | DSR modem status bit |
| st_ri | output | 1 | RI modem status bit |
| st_cd | output | 1 | CD modem status bit |

## Verification
The bench drives the modem pins in loopback to the opposite of the control bits. A design that still reads the pins in loopback would return the pin levels, and a design that swaps the RTS/DTR or OP1/OP2 pairing would show a single status bit in the wrong place. The bench also writes bit 6 and checks the readback, which catches a register that masks the reserved bit. It checks that DTR and the transmit pin go inactive in loopback, which catches a design that leaks the loop onto the external lines. Finally it counts the prescaler enables over a long window, so a counter that is one state too long or too short gives the wrong count or two enables in a row.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // Control byte layout; bit positions are the software-visible encoding.
  typedef struct packed {
    logic presc_div4; // 7: baud prescaler divides by four
    logic rsvd;       // 6: reserved, stored only
    logic xon_any;    // 5: any character resumes the transmitter
    logic loop_en;    // 4: internal loopback
    logic op2_ie;     // 3: interrupt pin enable / looped CD
    logic op1;        // 2: looped RI
    logic rts;        // 1: looped CTS
    logic dtr;        // 0: DTR pin / looped DSR
  } mdm_ctrl_t;

  localparam int CTRL_W = $bits(mdm_ctrl_t);
  localparam int STAT_N = 4; // cts, dsr, ri, cd
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output mdm_ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= mdm_ctrl_t'(wr_data);
  end
endmodule

// File: rtl/mdm_loop_route.sv
module mdm_loop_route
  import mdm_pkg::*;
#(
  parameter int N = STAT_N
) (
  input  logic         clk,
  input  logic         rst,
  input  mdm_ctrl_t    ctrl,
  input  logic [N-1:0] pin_n,     // active-low modem inputs, [3]=cts .. [0]=cd
  input  logic         rx_pin,
  input  logic         tx_ser,
  output logic [N-1:0] stat_q,    // active-high status, same ordering
  output logic         tx_pin_q,
  output logic         rx_rcv_q,
  output logic         dtr_n_q
);
  logic [N-1:0] loop_src;
  assign loop_src = {ctrl.rts, ctrl.dtr, ctrl.op1, ctrl.op2_ie};

  for (genvar i = 0; i < N; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= ctrl.loop_en ? loop_src[i] : ~pin_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin_q <= 1'b1;
      rx_rcv_q <= 1'b1;
      dtr_n_q  <= 1'b1;
    end else begin
      tx_pin_q <= ctrl.loop_en ? 1'b1   : tx_ser;
      rx_rcv_q <= ctrl.loop_en ? tx_ser : rx_pin;
      dtr_n_q  <= ctrl.loop_en ? 1'b1   : ~ctrl.dtr;
    end
  end
endmodule

// File: rtl/mdm_baud_prescale.sv
module mdm_baud_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  output logic ce_q
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      ce_q <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      ce_q <= ~div_sel | (cnt == LAST);
    end
  end
endmodule

// File: rtl/uart_mdmctl_top.sv
module uart_mdmctl_top
  import mdm_pkg::*;
#(
  parameter int PRESCALE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       modem_cts_n,
  input  logic       modem_dsr_n,
  input  logic       modem_ri_n,
  input  logic       modem_cd_n,
  input  logic       rx_pin,
  input  logic       tx_ser,
  output logic       tx_pin,
  output logic       rx_rcv,
  output logic       dtr_n,
  output logic       irq_oe,
  output logic       xon_any_en,
  output logic       baud_ce,
  output logic       st_cts,
  output logic       st_dsr,
  output logic       st_ri,
  output logic       st_cd
);
  mdm_ctrl_t         ctrl;
  logic [STAT_N-1:0] stat;

  mdm_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl)
  );

  mdm_loop_route #(.N(STAT_N)) u_route (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .pin_n({modem_cts_n, modem_dsr_n, modem_ri_n, modem_cd_n}),
    .rx_pin(rx_pin), .tx_ser(tx_ser),
    .stat_q(stat), .tx_pin_q(tx_pin), .rx_rcv_q(rx_rcv), .dtr_n_q(dtr_n)
  );

  mdm_baud_prescale #(.DIV(PRESCALE_DIV)) u_presc (
    .clk(clk), .rst(rst), .div_sel(ctrl.presc_div4), .ce_q(baud_ce)
  );

  assign rd_data    = ctrl;
  assign irq_oe     = ctrl.op2_ie;
  assign xon_any_en = ctrl.xon_any;
  assign {st_cts, st_dsr, st_ri, st_cd} = stat;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       modem_ri_n,
  input logic       tx_ser,
  input logic       tx_pin,
  input logic       rx_rcv,
  input logic       dtr_n,
  input logic       baud_ce,
  input logic       st_cts,
  input logic       st_ri
);
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));
  // R11
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
  // R8
  loop_serial_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |=> (tx_pin && rx_rcv == $past(tx_ser)));
  // R7
  loop_status_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |=> (st_ri == $past(rd_data[2]) && st_cts == $past(rd_data[1])));
  // R6
  pin_status_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[4] |=> st_ri == !$past(modem_ri_n));
  // R3
  loop_dtr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |=> dtr_n);
  // R9
  ce_full_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[7] |=> baud_ce);
  // R10
  ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && $past(rd_data[7]) && baud_ce) |=> !baud_ce);
endmodule

bind uart_mdmctl_top mdm_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .modem_ri_n(modem_ri_n), .tx_ser(tx_ser), .tx_pin(tx_pin), .rx_rcv(rx_rcv),
  .dtr_n(dtr_n), .baud_ce(baud_ce), .st_cts(st_cts), .st_ri(st_ri)
);

// File: tb/tb_uart_mdmctl_top.sv
module tb_uart_mdmctl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic rx_pin = 1'b1, tx_ser = 1'b1;
  logic tx_pin, rx_rcv, dtr_n, irq_oe, xon_any_en, baud_ce;
  logic st_cts, st_dsr, st_ri, st_cd;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_mdmctl_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .modem_cts_n(cts_n), .modem_dsr_n(dsr_n), .modem_ri_n(ri_n), .modem_cd_n(cd_n),
    .rx_pin(rx_pin), .tx_ser(tx_ser), .tx_pin(tx_pin), .rx_rcv(rx_rcv),
    .dtr_n(dtr_n), .irq_oe(irq_oe), .xon_any_en(xon_any_en), .baud_ce(baud_ce),
    .st_cts(st_cts), .st_dsr(st_dsr), .st_ri(st_ri), .st_cd(st_cd)
  );

  // {ctrl[7:0], pins_n{cts,dsr,ri,cd}, rx_pin, tx_ser,
  //  expected{dtr_n, irq_oe, xon, cts, dsr, ri, cd, tx_pin, rx_rcv}}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {8'h00, 4'b1111, 1'b1, 1'b0, 9'b1_0_0_0000_0_1},
    {8'h01, 4'b0101, 1'b0, 1'b1, 9'b0_0_0_1010_1_0},
    {8'h28, 4'b1010, 1'b1, 1'b1, 9'b1_1_1_0101_1_1},
    {8'h10, 4'b0000, 1'b0, 1'b0, 9'b1_0_0_0000_1_0},
    {8'h12, 4'b0000, 1'b0, 1'b1, 9'b1_0_0_1000_1_1},
    {8'h1F, 4'b1111, 1'b1, 1'b0, 9'b1_1_0_1111_1_0},
    {8'h15, 4'b0000, 1'b1, 1'b1, 9'b1_0_0_0110_1_1},
    {8'h6C, 4'b0011, 1'b0, 1'b0, 9'b1_1_1_1100_0_0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk); // registered outputs have settled
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    check("R1 rd_data", 32'(rd_data), 32'h00);
    check("R1 dtr_n/tx_pin", {30'd0, dtr_n, tx_pin}, 32'h3);
    check("R1 irq/xon/ce", {29'd0, irq_oe, xon_any_en, baud_ce}, 32'h0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R7 R8: table walk
    for (int i = 0; i < NV; i++) begin
      {cts_n, dsr_n, ri_n, cd_n} = VEC[i][14:11];
      rx_pin = VEC[i][10];
      tx_ser = VEC[i][9];
      write_ctrl(VEC[i][22:15]);
      check("R2 readback", 32'(rd_data), 32'(VEC[i][22:15]));
      check("R3-R8 outputs",
            32'({dtr_n, irq_oe, xon_any_en, st_cts, st_dsr, st_ri, st_cd, tx_pin, rx_rcv}),
            32'(VEC[i][8:0]));
    end

    // R7 R8: pins toggled inside loopback leave the outputs alone
    write_ctrl(8'h1A);
    {cts_n, dsr_n, ri_n, cd_n} = 4'b0110; rx_pin = 1'b0; tx_ser = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 pins ignored", 32'({st_cts, st_dsr, st_ri, st_cd}), 32'b1001);
    check("R8 rx from tx", 32'({tx_pin, rx_rcv}), 32'b11);
    tx_ser = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 rx follows tx", 32'({tx_pin, rx_rcv}), 32'b10);

    // R11: no write when strobe low
    wr_data = 8'hFF;
    repeat (4) @(negedge clk);
    check("R11 hold", 32'(rd_data), 32'h1A);

    // R9: enable every cycle with bit 7 clear
    write_ctrl(8'h00);
    begin
      int hi = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (baud_ce) hi++;
      end
      check("R9 ce count", 32'(hi), 32'd12);
    end

    // R10: one enable in four with bit 7 set
    write_ctrl(8'h80);
    @(negedge clk);
    begin
      int hi = 0;
      int pairs = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (baud_ce) hi++;
        if (baud_ce && prev) pairs++;
        prev = baud_ce;
      end
      check("R10 ce count", 32'(hi), 32'd10);
      check("R10 no back-to-back", 32'(pairs), 32'd0);
    end

    // R1: reset reapplied clears the register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 re-reset", 32'(rd_data), 32'h00);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule